// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor

This block is a small 32-bit processor core that retires exactly one instruction on every rising clock edge. It supports nine instructions: the register-to-register operations add, sub, and, or and set-on-less-than, the word load and store, branch-if-equal and an unconditional jump. Each cycle the program counter selects a word from instruction memory, the two source registers are read, the ALU computes a result or an address, and the PC, the register file and any data-memory store all update together at the next rising edge. The clock period must therefore cover the slowest path, which is a load: fetch, register read, address add, data read and write-back.

Instruction and data storage are two separate internal word arrays, so a fetch and a data access never compete. Each memory has a preload port that writes one word per cycle. The surrounding logic or a testbench fills them while reset is held. A debug read port returns any architectural register by index, which lets results be compared once a program has run.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register reads 0 on the debug port one cycle later.
- R2: R-type words (opcode 0, shift field 0) with function code 0x20, 0x22, 0x24 or 0x25 write rs+rt, rs-rt, rs AND rt or rs OR rt into register rd (bits [15:11]); rs is bits [25:21] and rt is bits [20:16].
- R3: R-type function code 0x2A writes 1 into rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Load (opcode 0x23) writes the data word at rs + sign-extended imm[15:0] into rt. Store (opcode 0x2B) writes rt to that address and does not change any register. Both use byte-address bits [DMEM_AW+1:2] as the word index.
- R5: Branch-if-equal (opcode 0x04) sets the next PC to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. Backward offsets are supported.
- R6: Jump (opcode 0x02) sets the next PC to {PC+4 [31:28], index[25:0], 2'b00}.
- R7: Register 0 always reads 0, and writes to it are discarded.
- R8: Any other opcode, an R-type word with an unlisted function code, and an R-type word with a non-zero shift field each act as a no-op: no register or memory write, and the next PC is PC+4.
- R9: Every non-control-transfer instruction advances the PC by exactly 4 per clock, and its register result is visible on the debug port right after that edge.
- R10: A pulse on `imem_ld_we` stores `ld_data` at word `imem_ld_addr`, and the stored word runs when the PC reaches it. `dmem_ld_we` does the same for data memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_ld_we | input | 1 | Write strobe for instruction preload |
| imem_ld_addr | input | IMEM_AW | Instruction word index for preload |
| dmem_ld_we | input | 1 | Write strobe for data preload (has priority over stores) |
| dmem_ld_addr | input | DMEM_AW | Data word index for preload |
| ld_data | input | 32 | Word written by either preload strobe |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_idx` |
| pc_o | output | 32 | Current program counter |

## Verification
The checker tests the control-flow rules on every cycle. It checks that reset forces the PC to zero, that the PC stays word aligned, and that each instruction moves the PC to PC+4, the branch target or the jump target according to its opcode and to a register comparison made apart from the ALU. It also checks that stores and undecoded opcodes leave the register file unwritten and that register 0 reads zero. Only the bench's programs can show that ALU results, signed comparison, load data, stores reached through a negative offset, and the effect of skipped instructions land in the right registers. The same holds for an overwritten program running correctly after a second reset.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int NREG   = 1 << RIDX_W;

    // primary opcodes
    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    // register-format function codes
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;   // write-back enable
        logic    dst_rd;   // destination is rd (else rt)
        logic    alu_imm;  // ALU B operand is immediate
        logic    mem_rd;   // write-back from data memory
        logic    mem_we;   // data store
        logic    branch;   // conditional on equality
        logic    jump;     // absolute region jump
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]        opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        fn;
    } rword_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c        = '0;
        c.alu_op = ALU_ADD;
        return c;
    endfunction

endpackage

// File: rtl/sc_mem.sv
module sc_mem #(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd,
    input  logic [RIDX_W-1:0] ra1,
    input  logic [RIDX_W-1:0] ra2,
    input  logic [RIDX_W-1:0] ra3,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    output logic [XLEN-1:0]   rd3
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import cpu_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    logic [XLEN-1:0] diff;
    logic            lt;

    assign diff = a - b;
    // signed less-than from operand signs and the difference sign
    assign lt   = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
    import cpu_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [4:0] shamt,
    input  logic [5:0] fn,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = ctrl_idle();
        unique case (opc)
            OPC_RTYPE: begin
                if (shamt == '0) begin
                    unique case (fn)
                        FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
                        FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
                        FN_AND: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_AND; end
                        FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
                        FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
                        default: ctrl = ctrl_idle();
                    endcase
                end
            end
            OPC_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ctrl = ctrl_idle();
        endcase
    end

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
    import cpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               imem_ld_we,
    input  logic [IMEM_AW-1:0] imem_ld_addr,
    input  logic               dmem_ld_we,
    input  logic [DMEM_AW-1:0] dmem_ld_addr,
    input  logic [XLEN-1:0]    ld_data,
    input  logic [RIDX_W-1:0]  dbg_idx,
    output logic [XLEN-1:0]    dbg_data,
    output logic [XLEN-1:0]    pc_o
);
    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt;
    logic [XLEN-1:0] instr;
    rword_t          iw;
    ctrl_t           ctrl;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, dm_rdata, wb_data;
    logic            alu_zero;
    logic            rf_we;
    logic [RIDX_W-1:0] rf_wa;
    logic            cpu_dm_we, dm_we;
    logic [DMEM_AW-1:0] dm_addr;
    logic [XLEN-1:0] dm_wdata;

    // fetch
    sc_mem #(.AW(IMEM_AW), .W(XLEN)) u_imem (
        .clk   (clk),
        .we    (imem_ld_we),
        .waddr (imem_ld_addr),
        .wdata (ld_data),
        .raddr (pc_q[IMEM_AW+1:2]),
        .rdata (instr)
    );

    assign iw    = rword_t'(instr);
    assign imm_x = sext16(instr[15:0]);

    sc_decoder u_dec (
        .opc   (iw.opc),
        .shamt (iw.shamt),
        .fn    (iw.fn),
        .ctrl  (ctrl)
    );

    // register read / write-back
    assign rf_we = ctrl.reg_we & ~rst;
    assign rf_wa = ctrl.dst_rd ? iw.rd : iw.rt;
    assign wb_data = ctrl.mem_rd ? dm_rdata : alu_y;

    sc_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (wb_data),
        .ra1 (iw.rs),
        .ra2 (iw.rt),
        .ra3 (dbg_idx),
        .rd1 (rd1),
        .rd2 (rd2),
        .rd3 (dbg_data)
    );

    // execute
    assign alu_b = ctrl.alu_imm ? imm_x : rd2;

    sc_alu u_alu (
        .a    (rd1),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: preload has priority over core stores
    assign cpu_dm_we = ctrl.mem_we & ~rst;
    assign dm_we     = dmem_ld_we | cpu_dm_we;
    assign dm_addr   = dmem_ld_we ? dmem_ld_addr : alu_y[DMEM_AW+1:2];
    assign dm_wdata  = dmem_ld_we ? ld_data : rd2;

    sc_mem #(.AW(DMEM_AW), .W(XLEN)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_addr),
        .wdata (dm_wdata),
        .raddr (alu_y[DMEM_AW+1:2]),
        .rdata (dm_rdata)
    );

    // next PC
    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_x[XLEN-3:0], 2'b00};
    assign j_tgt    = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump)                  pc_next = j_tgt;
        else if (ctrl.branch && alu_zero) pc_next = br_tgt;
        else                            pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk
    import cpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   instr,
    input logic [XLEN-1:0]   rd1,
    input logic [XLEN-1:0]   rd2,
    input logic              rf_we,
    input logic              dm_we,
    input logic [RIDX_W-1:0] dbg_idx,
    input logic [XLEN-1:0]   dbg_data
);
    logic [5:0] opc;
    logic       known_opc;
    logic       is_ctl;
    logic [XLEN-1:0] boff;

    assign opc       = instr[31:26];
    assign known_opc = (opc == OPC_RTYPE) || (opc == OPC_LOAD) || (opc == OPC_STORE)
                    || (opc == OPC_BEQ) || (opc == OPC_JUMP);
    assign is_ctl    = (opc == OPC_BEQ) || (opc == OPC_JUMP);
    assign boff      = {{14{instr[15]}}, instr[15:0], 2'b00};

    AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc == '0)); // R1

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00); // R9

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
        !is_ctl |=> (pc == $past(pc) + 32'd4)); // R9

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ && rd1 == rd2) |=> (pc == $past(pc) + 32'd4 + $past(boff))); // R5

    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ && rd1 != rd2) |=> (pc == $past(pc) + 32'd4)); // R5

    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JUMP) |=> (pc == {$past(pc[31:28] + {3'b000, pc[27:2] == 26'h3FFFFFF}),
                                      $past(instr[25:0]), 2'b00})); // R6

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == '0) |-> (dbg_data == '0)); // R7

    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_STORE) |-> !rf_we); // R4

    AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
        !known_opc |-> (!rf_we && !dm_we)); // R8

endmodule

bind sc_cpu sc_cpu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_q),
    .instr    (instr),
    .rd1      (rd1),
    .rd2      (rd2),
    .rf_we    (rf_we),
    .dm_we    (cpu_dm_we),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
);

// File: tb/tb_sc_cpu.sv
`timescale 1ns/1ps
module tb_sc_cpu;

    localparam int IAW = 6;
    localparam int DAW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           imem_ld_we = 1'b0;
    logic [IAW-1:0] imem_ld_addr = '0;
    logic           dmem_ld_we = 1'b0;
    logic [DAW-1:0] dmem_ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [4:0]     dbg_idx = '0;
    logic [31:0]    dbg_data;
    logic [31:0]    pc_o;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sc_cpu #(.IMEM_AW(IAW), .DMEM_AW(DAW)) dut (
        .clk          (clk),
        .rst          (rst),
        .imem_ld_we   (imem_ld_we),
        .imem_ld_addr (imem_ld_addr),
        .dmem_ld_we   (dmem_ld_we),
        .dmem_ld_addr (dmem_ld_addr),
        .ld_data      (ld_data),
        .dbg_idx      (dbg_idx),
        .dbg_data     (dbg_data),
        .pc_o         (pc_o)
    );

    // expected register file after the main program: {index, value}
    localparam logic [36:0] EXP [16] = '{
        {5'd0,  32'h0000_0000}, {5'd1,  32'h0000_0007},
        {5'd2,  32'hFFFF_FFFD}, {5'd3,  32'h0F0F_00FF},
        {5'd4,  32'h00FF_0F0F}, {5'd5,  32'h0000_0004},
        {5'd6,  32'hFFFF_FFF6}, {5'd7,  32'h000F_000F},
        {5'd8,  32'h0FFF_0FFF}, {5'd9,  32'h0000_0001},
        {5'd10, 32'h0000_0000}, {5'd11, 32'hFFFF_FFF6},
        {5'd12, 32'h0000_0000}, {5'd13, 32'h0000_0000},
        {5'd14, 32'h0000_0000}, {5'd15, 32'h0000_000E}
    };

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'h02, 26'(idx)};
    endfunction

    function automatic string tag_of(input int idx);
        case (idx)
            0:                    return "R7";
            1, 2, 3, 4, 11:       return "R4";
            5, 6, 7, 8:           return "R2";
            9, 10:                return "R3";
            12:                   return "R5";
            13:                   return "R6";
            default:              return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_imem(input int addr, input logic [31:0] w);
        @(negedge clk);
        imem_ld_we = 1'b1; imem_ld_addr = IAW'(addr); ld_data = w;
        @(negedge clk);
        imem_ld_we = 1'b0;
    endtask

    task automatic load_dmem(input int addr, input logic [31:0] w);
        @(negedge clk);
        dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(addr); ld_data = w;
        @(negedge clk);
        dmem_ld_we = 1'b0;
    endtask

    function automatic logic [31:0] reg_peek_dummy(input logic [31:0] v);
        return v;
    endfunction

    task automatic read_reg(input int idx, output logic [31:0] v);
        dbg_idx = 5'(idx);
        #0.5;
        v = reg_peek_dummy(dbg_data);
    endtask

    logic [31:0] prog [24];

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;

        prog[0]  = enc_i(6'h23, 0, 1, 0);        // lw r1,0(r0)
        prog[1]  = enc_i(6'h23, 0, 2, 4);        // lw r2,4(r0)
        prog[2]  = enc_i(6'h23, 0, 3, 8);        // lw r3,8(r0)
        prog[3]  = enc_i(6'h23, 0, 4, 12);       // lw r4,12(r0)
        prog[4]  = enc_r(1, 2, 5, 6'h20);        // add
        prog[5]  = enc_r(2, 1, 6, 6'h22);        // sub
        prog[6]  = enc_r(3, 4, 7, 6'h24);        // and
        prog[7]  = enc_r(3, 4, 8, 6'h25);        // or
        prog[8]  = enc_r(2, 1, 9, 6'h2A);        // slt -3<7
        prog[9]  = enc_r(1, 2, 10, 6'h2A);       // slt 7<-3
        prog[10] = enc_r(1, 1, 0, 6'h20);        // write to r0
        prog[11] = enc_r(0, 0, 0, 6'h20);        // plain no-effect add
        prog[12] = enc_i(6'h2B, 5, 6, -4);       // sw r6,-4(r5)
        prog[13] = enc_i(6'h23, 0, 11, 0);       // lw r11,0(r0)
        prog[14] = enc_i(6'h04, 1, 2, 5);        // beq not taken
        prog[15] = enc_i(6'h04, 9, 9, 1);        // beq taken, skip 16
        prog[16] = enc_r(1, 1, 12, 6'h20);       // skipped
        prog[17] = enc_j(20);                    // jump over 18,19
        prog[18] = enc_r(1, 1, 13, 6'h20);       // skipped
        prog[19] = enc_r(1, 1, 13, 6'h20);       // skipped
        prog[20] = 32'hFC00_0000;                // unknown opcode 0x3F
        prog[21] = enc_r(1, 1, 14, 6'h00);       // unlisted function code
        prog[22] = enc_r(1, 1, 15, 6'h20);       // add r15 = 14
        prog[23] = enc_i(6'h04, 0, 0, -1);       // self loop

        rst = 1'b1;
        for (int i = 0; i < 24; i++) load_imem(i, prog[i]);   // R10 preload
        load_dmem(0, 32'h0000_0007);
        load_dmem(1, 32'hFFFF_FFFD);
        load_dmem(2, 32'h0F0F_00FF);
        load_dmem(3, 32'h00FF_0F0F);

        // R1: reset state
        check("R1", "pc in reset", pc_o, 32'h0);
        for (int r = 0; r < 32; r++) begin
            read_reg(r, v);
            check("R1", $sformatf("reg %0d in reset", r), v, 32'h0);
        end

        // release and trace first cycles: R9
        dbg_idx = 5'd1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk);
            #1;
            check("R9", $sformatf("pc after %0d edges", k), pc_o, 32'(4 * k));
            if (k == 1) check("R9", "r1 visible after first edge", dbg_data, 32'h7);
        end

        repeat (40) @(posedge clk);
        #1;
        check("R5", "pc parked on backward self-branch", pc_o, 32'd92);

        // walk the expected-register table
        for (int e = 0; e < 16; e++) begin
            read_reg(int'(EXP[e][36:32]), v);
            check(tag_of(int'(EXP[e][36:32])), $sformatf("reg %0d", EXP[e][36:32]), v, EXP[e][31:0]);
        end

        // second reset: registers clear, new program replaces word 0..2
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "pc after re-reset", pc_o, 32'h0);
        read_reg(5, v);
        check("R1", "r5 cleared by re-reset", v, 32'h0);

        load_imem(0, enc_i(6'h23, 0, 1, 4));     // lw r1,4(r0) -> -3
        load_imem(1, enc_r(1, 0, 2, 6'h2A));     // slt r2 = (-3 < 0)
        load_imem(2, enc_i(6'h04, 0, 0, -1));    // self loop
        @(negedge clk);
        rst = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        read_reg(1, v);
        check("R10", "overwritten program load result", v, 32'hFFFF_FFFD);
        read_reg(2, v);
        check("R3", "negative vs zero signed compare", v, 32'h1);
        check("R10", "pc parked at new loop", pc_o, 32'd8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule